// File: doc/BRIEF.md
# Video Shift-Register Transfer Controller

This block sequences the read-transfer cycle that moves one row of video memory into the serial shift register feeding the display. The system raises an advance request some clocks before the actual load request. The controller then holds off new memory accesses and refreshes through a blocking output. It waits until the access sequencer and the refresh engine both report idle, and then stands ready for the load request.

When the load request rises in the ready state, the active-low transfer/output-enable strobe falls in the same cycle, with no register in the path. Row strobe follows on the next clock edge and column strobe one edge after that. The transfer ends when the load request falls or when the configured number of rising edges has elapsed since the load was accepted, whichever happens first. The row strobe, and the column strobe if it was reached, are then held for one more clock. After that the controller returns to idle. A load request that rises again while a cycle is still running raises a one-cycle error pulse.

States: IDLE (nothing pending), DRAIN (waiting for busy work to finish), READY (waiting for the load), RAS_ON (row strobe only), CAS_ON (row and column strobes), CLOSE (strobes held one clock after the transfer strobe releases). Transitions:
- IDLE→DRAIN when the advance request is high and the load request is low.
- DRAIN→IDLE when the advance request drops.
- DRAIN→READY when neither busy input is high.
- READY→RAS_ON when the load request is high.
- READY→IDLE when the advance request drops without a load.
- RAS_ON→CAS_ON while the load request holds and the edge limit has not been reached.
- RAS_ON→CLOSE and CAS_ON→CLOSE on load drop or on the edge limit.
- CLOSE→IDLE unconditionally.

Top module: `vsr_xfer_ctrl`

## Requirements
- R1: After reset, hold_new is 0, dtoe_n, ras_n and cas_n are 1, and xfer_err is 0.
- R2: hold_new is 1 in any cycle where adv_req is 1 or the controller is outside IDLE. In IDLE with adv_req 0 it is 0.
- R3: After the advance request, the controller leaves DRAIN only at an edge where acc_busy and rfsh_busy are both 0. A load_req seen in IDLE or DRAIN leaves dtoe_n at 1.
- R4: In READY, dtoe_n goes to 0 in the same cycle that load_req is 1, before ras_n or cas_n assert.
- R5: ras_n falls at the first rising edge after the load is accepted in READY. cas_n falls at the second, provided the load is still high and the edge limit (XFER_EDGES, default 4) is not yet reached.
- R6: With load_req held high, dtoe_n returns to 1 at the XFER_EDGES-th rising edge after the load was accepted. With the default this leaves dtoe_n low for exactly 4 sampled cycles.
- R7: If load_req falls while ras_n is low, dtoe_n returns to 1 in the same cycle.
- R8: After dtoe_n returns to 1, ras_n stays 0 for one more cycle. cas_n also stays 0 for that cycle if it was 0, and otherwise stays 1. Then all strobes are 1 and the controller is in IDLE.
- R9: If adv_req falls in DRAIN or READY with no load accepted, the controller returns to IDLE at the next edge and ras_n, cas_n and dtoe_n never assert.
- R10: A 0→1 transition of load_req while ras_n is low raises xfer_err to 1 for exactly the one cycle after that edge.
- R11: No new advance cycle starts while load_req is still high. The controller stays in IDLE and never asserts dtoe_n until load_req has been low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_req | input | 1 | Advance transfer request, high ahead of the load |
| load_req | input | 1 | Shift-register load request |
| acc_busy | input | 1 | Normal access sequencer is busy |
| rfsh_busy | input | 1 | Refresh engine is busy |
| hold_new | output | 1 | Blocks new accesses and refreshes from starting |
| dtoe_n | output | 1 | Active-low transfer / output-enable strobe |
| ras_n | output | 1 | Active-low row strobe for the transfer |
| cas_n | output | 1 | Active-low column strobe for the transfer |
| xfer_err | output | 1 | One-cycle pulse: load re-requested during an active cycle |

## Verification
The hardest condition to reach is the error pulse. It needs a fresh rising load request while the row strobe is still low. The only opening for that is the single CLOSE cycle after an early load drop, because the load must stay high to keep RAS_ON and CAS_ON running. The stimulus drops the load in CAS_ON and raises it again in the very next cycle. A second hard case is the early release during RAS_ON, which is the only way to see CLOSE with the column strobe still high. The stimulus reaches it by dropping the load one cycle after it was accepted.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DRAIN = 3'd1,
        ST_READY = 3'd2,
        ST_RAS   = 3'd3,
        ST_CAS   = 3'd4,
        ST_CLOSE = 3'd5
    } xfer_state_e;

    function automatic logic strobe_phase(input xfer_state_e s);
        return (s == ST_RAS) || (s == ST_CAS);
    endfunction

endpackage

// File: rtl/vsr_edge_timer.sv
module vsr_edge_timer
    import vsr_pkg::*;
#(
    parameter int XFER_EDGES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  xfer_state_e state_i,
    input  logic        load_req,
    output logic        limit_o
);
    localparam int CW = $clog2(XFER_EDGES + 1);
    localparam logic [CW-1:0] LAST = CW'(XFER_EDGES - 1);

    logic [CW-1:0] edge_cnt;
    logic          start;

    assign start = (state_i == ST_READY) && load_req;

    // edge_cnt equals the number of rising edges since the load was accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= '0;
        end else if (start) begin
            edge_cnt <= CW'(1);
        end else if (strobe_phase(state_i) && edge_cnt != LAST + CW'(1)) begin
            edge_cnt <= edge_cnt + CW'(1);
        end else if (!strobe_phase(state_i)) begin
            edge_cnt <= '0;
        end
    end

    // true when the coming edge is the last one the transfer strobe may span
    assign limit_o = strobe_phase(state_i) && (edge_cnt >= LAST);

endmodule

// File: rtl/vsr_fsm.sv
module vsr_fsm
    import vsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv_req,
    input  logic        load_req,
    input  logic        acc_busy,
    input  logic        rfsh_busy,
    input  logic        limit_i,
    output xfer_state_e state_o
);
    xfer_state_e state_q, state_d;
    logic        drained;
    logic        release_now;

    assign drained     = !acc_busy && !rfsh_busy;
    assign release_now = !load_req || limit_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (adv_req && !load_req) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!adv_req)     state_d = ST_IDLE;
                else if (drained) state_d = ST_READY;
            end
            ST_READY: begin
                if (load_req)     state_d = ST_RAS;
                else if (!adv_req) state_d = ST_IDLE;
            end
            ST_RAS: begin
                if (release_now) state_d = ST_CLOSE;
                else             state_d = ST_CAS;
            end
            ST_CAS: begin
                if (release_now) state_d = ST_CLOSE;
            end
            ST_CLOSE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/vsr_out_dec.sv
module vsr_out_dec
    import vsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  xfer_state_e state_i,
    input  logic        adv_req,
    input  logic        load_req,
    output logic        hold_new,
    output logic        dtoe_n,
    output logic        ras_n,
    output logic        cas_n
);
    logic cas_was;

    // remembers whether the column strobe was reached before CLOSE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cas_was <= 1'b0;
        else        cas_was <= (state_i == ST_CAS);
    end

    always_comb begin
        hold_new = adv_req;
        dtoe_n   = 1'b1;
        ras_n    = 1'b1;
        cas_n    = 1'b1;
        unique case (state_i)
            ST_IDLE: begin
            end
            ST_DRAIN: begin
                hold_new = 1'b1;
            end
            ST_READY: begin
                hold_new = 1'b1;
                dtoe_n   = !load_req;
            end
            ST_RAS: begin
                hold_new = 1'b1;
                dtoe_n   = !load_req;
                ras_n    = 1'b0;
            end
            ST_CAS: begin
                hold_new = 1'b1;
                dtoe_n   = !load_req;
                ras_n    = 1'b0;
                cas_n    = 1'b0;
            end
            ST_CLOSE: begin
                hold_new = 1'b1;
                ras_n    = 1'b0;
                cas_n    = !cas_was;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/vsr_err_det.sv
module vsr_err_det
    import vsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  xfer_state_e state_i,
    input  logic        load_req,
    output logic        xfer_err
);
    logic load_q;
    logic busy_cycle;

    assign busy_cycle = strobe_phase(state_i) || (state_i == ST_CLOSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q   <= 1'b0;
            xfer_err <= 1'b0;
        end else begin
            load_q   <= load_req;
            xfer_err <= load_req && !load_q && busy_cycle;
        end
    end

endmodule

// File: rtl/vsr_xfer_ctrl.sv
module vsr_xfer_ctrl
    import vsr_pkg::*;
#(
    parameter int XFER_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_req,
    input  logic load_req,
    input  logic acc_busy,
    input  logic rfsh_busy,
    output logic hold_new,
    output logic dtoe_n,
    output logic ras_n,
    output logic cas_n,
    output logic xfer_err
);
    xfer_state_e state;
    logic        limit;

    vsr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_req   (adv_req),
        .load_req  (load_req),
        .acc_busy  (acc_busy),
        .rfsh_busy (rfsh_busy),
        .limit_i   (limit),
        .state_o   (state)
    );

    vsr_edge_timer #(.XFER_EDGES(XFER_EDGES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (state),
        .load_req (load_req),
        .limit_o  (limit)
    );

    vsr_out_dec u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (state),
        .adv_req  (adv_req),
        .load_req (load_req),
        .hold_new (hold_new),
        .dtoe_n   (dtoe_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n)
    );

    vsr_err_det u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (state),
        .load_req (load_req),
        .xfer_err (xfer_err)
    );

endmodule

// File: rtl/vsr_xfer_chk.sv
module vsr_xfer_chk #(
    parameter int XFER_EDGES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic adv_req,
    input logic load_req,
    input logic acc_busy,
    input logic rfsh_busy,
    input logic hold_new,
    input logic dtoe_n,
    input logic ras_n,
    input logic cas_n,
    input logic xfer_err
);
    localparam int RW = $clog2(XFER_EDGES + 2) + 1;
    logic [RW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      low_run <= '0;
        else if (dtoe_n) low_run <= '0;
        else if (low_run != '1) low_run <= low_run + RW'(1);
    end

    p_hold_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv_req |-> hold_new);

    p_hold_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> hold_new);

    p_dtoe_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dtoe_n |-> load_req);

    p_ras_after_dtoe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !$past(dtoe_n));

    p_cas_inside_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    p_dtoe_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= RW'(XFER_EDGES));

    p_ras_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> $past(dtoe_n));

    p_err_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |=> !xfer_err);

endmodule

bind vsr_xfer_ctrl vsr_xfer_chk #(.XFER_EDGES(XFER_EDGES)) u_chk (.*);

// File: tb/vsr_xfer_ctrl_test.sv
module vsr_xfer_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv_req = 1'b0, load_req = 1'b0, acc_busy = 1'b0, rfsh_busy = 1'b0;
    logic hold_new, dtoe_n, ras_n, cas_n, xfer_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected vector: {hold_new, dtoe_n, ras_n, cas_n, xfer_err}
    logic [4:0] exp_q[$];
    string      tag_q[$];

    localparam logic [4:0] V_IDLE = 5'b01110;
    localparam logic [4:0] V_HOLD = 5'b11110;

    always #4 clk = ~clk;

    vsr_xfer_ctrl uut (
        .clk(clk), .rst_n(rst_n), .adv_req(adv_req), .load_req(load_req),
        .acc_busy(acc_busy), .rfsh_busy(rfsh_busy), .hold_new(hold_new),
        .dtoe_n(dtoe_n), .ras_n(ras_n), .cas_n(cas_n), .xfer_err(xfer_err)
    );

    task automatic step(input logic a, input logic l, input logic ab,
                        input logic rb, input logic [4:0] e, input string tag);
        @(negedge clk);
        adv_req = a; load_req = l; acc_busy = ab; rfsh_busy = rb;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: pops one expected item per cycle and compares
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [4:0] e;
            logic [4:0] got;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            got = {hold_new, dtoe_n, ras_n, cas_n, xfer_err};
            checks++;
            if (got !== e) begin
                fails++;
                $display("FAIL %s: {hold,dtoe_n,ras_n,cas_n,err} actual=%b expected=%b",
                         t, got, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step(0,0,0,0, V_IDLE,   "R1");
        // timeout transfer, drain held by both busy inputs
        step(1,0,1,0, V_HOLD,   "R2");
        step(1,0,1,0, V_HOLD,   "R3");
        step(1,0,0,1, V_HOLD,   "R3");
        step(1,0,0,0, V_HOLD,   "R3");
        step(1,1,0,0, 5'b10110, "R4");
        step(1,1,0,0, 5'b10010, "R5");
        step(1,1,0,0, 5'b10000, "R5");
        step(1,1,0,0, 5'b10000, "R6");
        step(1,1,0,0, 5'b11000, "R6");
        step(1,1,0,0, V_HOLD,   "R8");
        step(1,1,0,0, V_HOLD,   "R11");
        step(1,1,0,0, V_HOLD,   "R11");
        step(0,0,0,0, V_IDLE,   "R2");

        // early drop during row strobe, load ignored in drain
        step(1,0,0,0, V_HOLD,   "R2");
        step(1,1,0,0, V_HOLD,   "R3");
        step(1,1,0,0, 5'b10110, "R4");
        step(1,0,0,0, 5'b11010, "R7");
        step(1,0,0,0, 5'b11010, "R8");
        step(0,0,0,0, V_IDLE,   "R8");

        // drop during column strobe, then re-request in CLOSE
        step(1,0,0,0, V_HOLD,   "R2");
        step(1,0,0,0, V_HOLD,   "R3");
        step(0,1,0,0, 5'b10110, "R4");
        step(0,1,0,0, 5'b10010, "R5");
        step(0,0,0,0, 5'b11000, "R7");
        step(0,1,0,0, 5'b11000, "R8");
        step(0,1,0,0, 5'b01111, "R10");
        step(0,0,0,0, V_IDLE,   "R10");

        // aborts from DRAIN and READY
        step(1,0,0,1, V_HOLD,   "R2");
        step(0,0,0,1, V_HOLD,   "R9");
        step(0,1,0,0, V_IDLE,   "R9");
        step(0,0,0,0, V_IDLE,   "R9");
        step(1,0,0,0, V_HOLD,   "R2");
        step(1,0,0,0, V_HOLD,   "R9");
        step(0,0,0,0, V_HOLD,   "R9");
        step(0,0,0,0, V_IDLE,   "R9");
        step(0,1,0,0, V_IDLE,   "R3");
        step(0,0,0,0, V_IDLE,   "R3");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule